// File: doc/BRIEF.md
# Packed-Control Performance Monitor

This block counts clock cycles and two selectable hardware events for profiling. It has three 32-bit counters: one counts cycles and two count events. Each event counter picks the event it counts through an 8-bit code held in a control word. Events arrive on a wide strobe vector with one bit per event code. A bit is high for one clock each time its event occurs.

One control word holds all configuration and status: the global enable, the self-clearing counter resets, the cycle divider select, three interrupt enables, three overflow flags and both event codes. Software reads the control word, handles the overflowed counters and writes the same value back. Writing a 1 to a flag bit clears that flag. A single level interrupt goes high while any flag is set together with its enable.

Access uses a plain register port. A 2-bit index selects the control word or one of the three counters. Read data is combinational from the index, and a write takes effect at the next clock edge.

Top module: `perf_mon`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq` is low.
- R2: Register index 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A write to index 1, 2 or 3 loads that counter and the value reads back unchanged.
- R3: Control word fields:
  - bit 0: enable
  - bit 1: event-counter reset
  - bit 2: cycle-counter reset
  - bit 3: divide
  - bits 6:4: interrupt enables, in the order event 0, event 1, cycle
  - bits 10:8: flags, in the same order
  - bits 19:12: code for event counter 0
  - bits 27:20: code for event counter 1

  Bits 1, 2, 7, 11 and 31:28 always read 0.
- R4: With enable set and divide clear, the cycle counter advances by one on every clock.
- R5: With divide set, the cycle counter advances only on every 64th enabled clock. A 6-bit prescaler counts enabled clocks, and the counter advances when the prescaler holds 63. A cycle-counter reset also clears the prescaler.
- R6: An enabled event counter advances in a cycle when the strobe bit at its selected code is high. Only codes 0x00-0x0D, 0x10-0x12 and 0x14-0x16 count. Code 0xFF and every other code never count.
- R7: While enable is 0, all three counters hold their values.
- R8: Writing 1 to bit 1 clears both event counters at that edge, and writing 1 to bit 2 clears the cycle counter at that edge. Either reset wins over a same-cycle increment.
- R9: A counter that advances from 0xFFFFFFFF becomes 0 and sets its flag at the same edge.
- R10: A control write with a 1 in a flag bit clears that flag. If that counter wraps on the same edge, the flag stays set.
- R11: `irq` is high exactly while some flag and its matching interrupt enable are both 1.
- R12: A register write to a counter wins over an increment of that counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_strobe | input | 256 | One single-cycle strobe per event code |
| reg_addr | input | 2 | Register index |
| reg_we | input | 1 | Write strobe for the indexed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The embedded properties watch the following on every cycle:
- the wrap-to-zero and load and clear priorities in each counter;
- that a flag follows a wrap, even against a same-edge clear;
- that the counters freeze while disabled, and that the divided cycle counter stays still between prescaler terminal counts;
- that `irq` changes only after a wrap or a control write.

The exact field layout of the control word needs the bench's scenarios. So do the 64-clock divide period, the filtering of invalid and unused event codes, the reset and load priority against live strobes, and the set-versus-clear race on a flag. The bench checks each of these against its behavioural model.

// File: rtl/perf_mon_pkg.sv
// perf_mon_pkg: shared constants, control state type and event-code
// validity for the performance monitor. Assumes two event counters plus one
// cycle counter and the fixed control word layout of the block.
package perf_mon_pkg;

    localparam int SEL_W  = 8;
    localparam int NSLOT  = 3;          // counters, in flag-bit order
    localparam int IDX_E0 = 0;
    localparam int IDX_E1 = 1;
    localparam int IDX_CY = 2;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CYC  = 2'd1;
    localparam logic [1:0] A_EV0  = 2'd2;
    localparam logic [1:0] A_EV1  = 2'd3;

    typedef struct packed {
        logic             en;
        logic             div;
        logic [2:0]       ien;
        logic [2:0]       flag;
        logic [SEL_W-1:0] sel0;
        logic [SEL_W-1:0] sel1;
    } ctrl_t;

    // Register index of a counter slot.
    function automatic logic [1:0] slot_addr(input int s);
        case (s)
            IDX_E0:  return A_EV0;
            IDX_E1:  return A_EV1;
            default: return A_CYC;
        endcase
    endfunction

    // True for event codes that a counter may count.
    function automatic logic code_valid(input logic [SEL_W-1:0] c);
        return (c <= 8'h0D) || (c >= 8'h10 && c <= 8'h12) ||
               (c >= 8'h14 && c <= 8'h16);
    endfunction

endpackage

// File: rtl/pm_counter.sv
// pm_counter: one loadable wrap-around counter. Priority is clear, then
// load, then increment. Reports a one-cycle wrap when it advances from all
// ones. Assumes clr and ld come from the register port and inc from the
// event or cycle logic.
module pm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic adv;

    // Increment only when no clear or load takes the edge.
    assign adv  = inc && !clr && !ld;
    assign wrap = adv && (&cnt);

    // Counter register with clear > load > increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (inc) cnt <= cnt + 1'b1;
    end

    a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !ld && (&cnt)) |=> (cnt == '0));
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/pm_prescale.sv
// pm_prescale: free-running divider of enabled clocks. term is high while
// the count is at its maximum, so one term per 2**DIV_LOG2 advances.
// Assumes clr is the cycle-counter reset pulse.
module pm_prescale #(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic term
);
    logic [DIV_LOG2-1:0] pre_q;

    assign term = &pre_q;

    // Count enabled clocks, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre_q <= '0;
        else if (adv)      pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/pm_evt_match.sv
// pm_evt_match: picks the strobe addressed by an event code and reports a
// countable hit. Codes outside the valid set, including the unused code
// 0xFF, never hit. Assumes strobes are one cycle wide.
module pm_evt_match
    import perf_mon_pkg::*;
#(
    parameter int N_CODES = 256
) (
    input  logic               en,
    input  logic [SEL_W-1:0]   sel,
    input  logic [N_CODES-1:0] strobes,
    output logic               hit
);
    localparam int IW = $clog2(N_CODES);

    logic [IW-1:0] idx;

    // Index the strobe vector and gate with enable and code validity.
    always_comb begin
        idx = IW'(sel);
        hit = en && code_valid(sel) && strobes[idx];
    end
endmodule

// File: rtl/pm_ctrl.sv
// pm_ctrl: the packed control word. Holds enable, divide, interrupt
// enables, overflow flags and event codes. Produces the self-clearing reset
// pulses and the interrupt. Flags clear on a written 1 unless a wrap sets
// them on the same edge.
module pm_ctrl
    import perf_mon_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    input  logic [2:0]  wrap,
    output ctrl_t       st,
    output logic        rst_evt,
    output logic        rst_cyc,
    output logic [31:0] rd_word,
    output logic        irq
);
    logic unused_wbits;

    assign unused_wbits = ^{wdata[31:28], wdata[11], wdata[7]};
    assign rst_evt = we && wdata[1];
    assign rst_cyc = we && wdata[2];
    assign irq     = |(st.flag & st.ien);

    // Control state: configuration on write, flags set by wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            if (we) begin
                st.en   <= wdata[0];
                st.div  <= wdata[3];
                st.ien  <= wdata[6:4];
                st.sel0 <= wdata[19:12];
                st.sel1 <= wdata[27:20];
            end
            st.flag <= (st.flag & ~(we ? wdata[10:8] : 3'b000)) | wrap;
        end
    end

    // Read view with reserved and reset bits as zero.
    always_comb begin
        rd_word        = '0;
        rd_word[0]     = st.en;
        rd_word[3]     = st.div;
        rd_word[6:4]   = st.ien;
        rd_word[10:8]  = st.flag;
        rd_word[19:12] = st.sel0;
        rd_word[27:20] = st.sel1;
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_flag_chk
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[i] |=> st.flag[i]);
    end

    a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((|wrap) || we));
    a_r11_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(we));
endmodule

// File: rtl/perf_mon.sv
// perf_mon: performance monitor top. One cycle counter (optionally divided)
// and two event counters, all controlled through one packed control word
// over a simple indexed register port. Assumes CNT_W <= 32.
module perf_mon
    import perf_mon_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int DIV_LOG2 = 6,
    parameter int N_CODES  = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CODES-1:0] evt_strobe,
    input  logic [1:0]         reg_addr,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq
);
    ctrl_t            st;
    logic             rst_evt, rst_cyc, pre_term, cyc_tick;
    logic [31:0]      ctrl_rd;
    logic [NSLOT-1:0] inc_v, wrap_v;
    logic [1:0]       hit;
    logic [SEL_W-1:0] sel_v [2];
    logic [CNT_W-1:0] cnt_q [NSLOT];

    pm_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(reg_we && reg_addr == A_CTRL),
        .wdata(reg_wdata), .wrap(wrap_v), .st(st), .rst_evt(rst_evt),
        .rst_cyc(rst_cyc), .rd_word(ctrl_rd), .irq(irq)
    );

    pm_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(rst_cyc), .adv(st.en), .term(pre_term)
    );

    // Cycle tick: every enabled clock, or prescaler terminal when dividing.
    assign cyc_tick = st.en && (!st.div || pre_term);
    assign sel_v[0] = st.sel0;
    assign sel_v[1] = st.sel1;

    for (genvar e = 0; e < 2; e++) begin : g_match
        pm_evt_match #(.N_CODES(N_CODES)) u_match (
            .en(st.en), .sel(sel_v[e]), .strobes(evt_strobe), .hit(hit[e])
        );
    end

    assign inc_v[IDX_E0] = hit[0];
    assign inc_v[IDX_E1] = hit[1];
    assign inc_v[IDX_CY] = cyc_tick;

    for (genvar s = 0; s < NSLOT; s++) begin : g_cnt
        pm_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .clr((s == IDX_CY) ? rst_cyc : rst_evt),
            .ld(reg_we && reg_addr == slot_addr(s)),
            .ld_val(reg_wdata[CNT_W-1:0]),
            .inc(inc_v[s]), .cnt(cnt_q[s]), .wrap(wrap_v[s])
        );
    end

    // Read mux by register index.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_rd;
            A_CYC:   reg_rdata = 32'(cnt_q[IDX_CY]);
            A_EV0:   reg_rdata = 32'(cnt_q[IDX_E0]);
            default: reg_rdata = 32'(cnt_q[IDX_E1]);
        endcase
    end

    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.en && !reg_we) |=>
        ($stable(cnt_q[IDX_CY]) && $stable(cnt_q[IDX_E0]) && $stable(cnt_q[IDX_E1])));
    a_r5_divided_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st.en && st.div && !pre_term && !reg_we) |=> $stable(cnt_q[IDX_CY]));
endmodule

// File: tb/perf_mon_tb.sv
`timescale 1ns/1ps
module perf_mon_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] ev = '0;
    logic [1:0]   reg_addr = '0;
    logic         reg_we = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq;
    int           nchk = 0;
    int           nfail = 0;
    bit           done = 1'b0;

    // Behavioural reference state.
    logic         m_en, m_div;
    logic [2:0]   m_ien, m_flag;
    logic [7:0]   m_sel0, m_sel1;
    logic [31:0]  m_cnt [3];   // 0: event 0, 1: event 1, 2: cycle
    int           m_pre;

    always #4 clk = ~clk;     // 125 MHz

    perf_mon u_dut (
        .clk(clk), .rst_n(rst_n), .evt_strobe(ev), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic bit ok_code(input logic [7:0] c);
        int v = int'(c);
        return (v >= 0 && v <= 13) || (v >= 16 && v <= 18) || (v >= 20 && v <= 22);
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return {4'h0, m_sel1, m_sel0, 1'b0, m_flag, 1'b0, m_ien, m_div, 2'b00, m_en};
            2'd1: return m_cnt[2];
            2'd2: return m_cnt[0];
            default: return m_cnt[1];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference model: one step per clock edge from pre-edge state.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_div = 0; m_ien = 0; m_flag = 0; m_sel0 = 0; m_sel1 = 0;
            m_cnt[0] = 0; m_cnt[1] = 0; m_cnt[2] = 0; m_pre = 0;
        end else begin
            bit we0, r_e, r_c, tick;
            bit [2:0] hitv, wrp;
            we0  = reg_we && reg_addr == 2'd0;
            r_e  = we0 && reg_wdata[1];
            r_c  = we0 && reg_wdata[2];
            tick = m_en && (!m_div || m_pre == 63);
            hitv[0] = m_en && ok_code(m_sel0) && ev[m_sel0];
            hitv[1] = m_en && ok_code(m_sel1) && ev[m_sel1];
            hitv[2] = tick;
            wrp = 0;
            for (int k = 0; k < 3; k++) begin
                bit clr, ld;
                clr = (k == 2) ? r_c : r_e;
                ld  = reg_we && reg_addr == ((k == 2) ? 2'd1 : (k == 0) ? 2'd2 : 2'd3);
                if (clr) m_cnt[k] = 0;
                else if (ld) m_cnt[k] = reg_wdata;
                else if (hitv[k]) begin
                    if (m_cnt[k] == 32'hFFFF_FFFF) wrp[k] = 1;
                    m_cnt[k] = m_cnt[k] + 1;
                end
            end
            if (r_c) m_pre = 0;
            else if (m_en) m_pre = (m_pre + 1) % 64;
            if (we0) begin
                m_flag = m_flag & ~reg_wdata[10:8];
                m_en = reg_wdata[0]; m_div = reg_wdata[3]; m_ien = reg_wdata[6:4];
                m_sel0 = reg_wdata[19:12]; m_sel1 = reg_wdata[27:20];
            end
            m_flag = m_flag | wrp;
        end
    end

    // Per-clock comparison of the port outputs against the model.
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            case (reg_addr)
                2'd0: chk("R3 ctrl", reg_rdata, m_read(reg_addr));
                2'd1: chk("R4 cycle", reg_rdata, m_read(reg_addr));
                default: chk("R6 event", reg_rdata, m_read(reg_addr));
            endcase
            chk("R11 irq", {31'b0, irq}, {31'b0, |(m_flag & m_ien)});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.2;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1 ctrl", 0, 0); rd("R1 cycle", 1, 0); rd("R1 ev0", 2, 0); rd("R1 ev1", 3, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        idle(1);
        // R2 index map and load
        wr(1, 32'hA5A5_0001); wr(2, 32'h1234_5678); wr(3, 32'hCAFE_0003);
        rd("R2 cycle", 1, 32'hA5A5_0001); rd("R2 ev0", 2, 32'h1234_5678);
        rd("R2 ev1", 3, 32'hCAFE_0003);
        idle(1);
        // R3 layout, reserved bits; R7 still frozen
        wr(0, 32'hFFFF_FFF8);
        rd("R3 layout", 0, 32'h0FFF_F078);
        idle(4);
        rd("R7 frozen", 1, 32'hA5A5_0001);
        // R4 per-clock cycle count
        wr(0, 32'h0000_0005);
        idle(10);
        rd("R4 ten clocks", 1, 32'd10);
        // R5 divided count
        wr(0, 32'h0000_000D);
        idle(128);
        rd("R5 divide by 64", 1, 32'd2);
        // R6 invalid and unused codes
        ev = '1;
        wr(0, 32'h0FF0_E003);
        idle(10);
        rd("R6 invalid code", 2, 0); rd("R6 unused code", 3, 0);
        wr(0, 32'h0051_6003);
        idle(5);
        rd("R6 ev0 count", 2, 32'd5); rd("R6 ev1 count", 3, 32'd5);
        // R7 freeze and hold
        wr(0, 32'h0051_6000);
        idle(7);
        rd("R7 hold ev0", 2, 32'd6);
        // R8 reset beats increment
        wr(0, 32'h0051_6001);
        idle(3);
        wr(0, 32'h0051_6003);
        rd("R8 ev0 cleared", 2, 0); rd("R8 ev1 cleared", 3, 0);
        wr(0, 32'h0051_6005);
        rd("R8 cycle cleared", 1, 0);
        // R12 load beats increment
        wr(3, 32'd100);
        rd("R12 load wins", 3, 32'd100);
        idle(1);
        // R9 wrap and R11 interrupt
        ev = '0; ev[7] = 1'b1;
        wr(0, 32'h0000_7010);
        wr(2, 32'hFFFF_FFFE);
        wr(0, 32'h0000_7011);
        idle(2);
        rd("R9 wrapped", 2, 0);
        rd("R9 flag", 0, 32'h0000_7111);
        chk("R11 irq set", {31'b0, irq}, 1);
        // R10 clear by writing 1
        wr(0, 32'h0000_7111);
        rd("R10 cleared", 0, 32'h0000_7011);
        chk("R11 irq low", {31'b0, irq}, 0);
        // R10 set wins over clear
        wr(0, 32'h0000_7010);
        wr(2, 32'hFFFF_FFFF);
        wr(0, 32'h0000_7011);
        wr(0, 32'h0000_7111);
        rd("R10 set wins", 0, 32'h0000_7111);
        chk("R11 irq after race", {31'b0, irq}, 1);
        idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule